// File: doc/BRIEF.md
# Thread Interrupt Context Presenter

This block keeps the interrupt management state of one processor thread and decides when that thread takes an external exception. A routing engine upstream delivers notifications, each tagged with a 3-bit priority and a flag that tells whether it came through the guest (OS) path. The block keeps one register context: a pending buffer with one bit per priority, the most favoured pending priority derived from it, the current processor priority that masks delivery, and a notification source register that holds the exception flag. It drives a single exception line. In all priorities a lower number is more favoured.

Software reaches the context through a register port. The top two address bits select one of four privilege views (physical, hypervisor, OS, user) onto the same registers, and the low four bits select the register. Software can read the acknowledge offset to take the most favoured pending interrupt. It can also write the current priority to raise or lower the mask. The user view may only read, and its reads have no side effects.

Top module: `tctx_presenter`

## Requirements
- R1: After synchronous reset the pending buffer, the current priority and the source register are all zero, the exception line is low, and the pending-priority register reads 0xFF.
- R2: An accepted notification of priority p sets pending-buffer bit (7 - p) at the next clock edge. Bits that are already set stay set.
- R3: The pending-priority register (offset 3) reads as the lowest priority number whose pending bit is set. It reads 0xFF when the buffer is empty.
- R4: A notification of priority 7 with ntf_os_path = 1 is dropped and leaves the pending buffer unchanged. With ntf_os_path = 0 it is accepted.
- R5: After every clock edge the source register (offset 0) is 0x80 when pending priority < current priority and 0x00 otherwise. irq_out equals bit 7 of the source register.
- R6: A write to offset 1 from views 0, 1 or 2 loads the current priority. The exception line is re-evaluated against the new value at that same edge.
- R7: Writes from the user view (view 3) change no register. Reads from the user view return the same data as from the other views.
- R8: A read of offset 4 from views 0 to 2 returns {source register, pending priority} on acc_rdata[15:0] in the same cycle. At the edge it clears that priority's pending bit, loads the current priority with it, and re-evaluates the exception line, which drops when no other notification arrives.
- R9: An acknowledge read while the pending buffer is empty returns {source register, 0xFF} and changes no state.
- R10: An acknowledge read from the user view returns the same data but clears no pending bit and leaves the current priority unchanged.
- R11: A notification that arrives in the same cycle as an acknowledge is applied together with it: the acknowledged bit is cleared and the new bit is set.
- R12: Reads of offsets 5 to 15 return zero. Writes to any offset other than 1 change no register. acc_rdata is zero when no read is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ntf_valid | input | 1 | Notification strobe from the routing engine |
| ntf_os_path | input | 1 | Notification arrived through the guest (OS) path |
| ntf_prio | input | 3 | Notification priority, 0 most favoured |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | [5:4] view select, [3:0] register offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 16 | Read data, valid in the cycle of the read |
| irq_out | output | 1 | Exception line to the thread |

## Verification
The bench first drives directed sequences: single notifications below and above the mask, stacked notifications that show the pending-priority encoder picks the most favoured, and acknowledges repeated until the buffer empties. These separate a correct pending-bit mapping from a reversed one, and a working mask compare from an inverted or non-strict one. It also tries priority 7 through both paths, writes and acknowledges from every view, and a notification coinciding with an acknowledge; together these tell the privilege filtering and the merge of the two updates apart. A long stretch of mixed random traffic then checks read data and the exception line against the reference model on every clock.

// File: rtl/tctx_pkg.sv
package tctx_pkg;

    localparam int PRIO_LEVELS = 8;
    localparam int PRIO_W      = $clog2(PRIO_LEVELS);
    localparam int REG_W       = 8;
    localparam int VIEW_W      = 2;
    localparam int OFF_W       = 4;
    localparam int ADDR_W      = VIEW_W + OFF_W;
    localparam int RDATA_W     = 2 * REG_W;
    localparam int NSR_EXC_BIT = REG_W - 1;

    localparam logic [REG_W-1:0] PRIO_NONE = {REG_W{1'b1}};
    localparam logic [REG_W-1:0] NSR_EXC   = REG_W'(1) << NSR_EXC_BIT;

    typedef enum logic [VIEW_W-1:0] {
        VIEW_PHYS = 2'd0,
        VIEW_HYP  = 2'd1,
        VIEW_OS   = 2'd2,
        VIEW_USER = 2'd3
    } view_e;

    localparam logic [OFF_W-1:0] OFF_NSR  = 4'd0;
    localparam logic [OFF_W-1:0] OFF_CPPR = 4'd1;
    localparam logic [OFF_W-1:0] OFF_IPB  = 4'd2;
    localparam logic [OFF_W-1:0] OFF_PIPR = 4'd3;
    localparam logic [OFF_W-1:0] OFF_ACK  = 4'd4;

    typedef struct packed {
        logic             rd;
        logic             cppr_wr;
        logic             ack_req;
        logic [OFF_W-1:0] off;
    } acc_op_t;

    function automatic logic [REG_W-1:0] prio_mask(input logic [PRIO_W-1:0] p);
        return REG_W'(1) << (PRIO_LEVELS - 1 - int'(p));
    endfunction

endpackage

// File: rtl/tctx_prio_enc.sv
module tctx_prio_enc
    import tctx_pkg::*;
(
    input  logic [PRIO_LEVELS-1:0] ipb,
    output logic [PRIO_W-1:0]      lvl,
    output logic                   any
);
    logic [PRIO_LEVELS-1:0] by_prio;

    genvar g;
    for (g = 0; g < PRIO_LEVELS; g++) begin : g_remap
        assign by_prio[g] = ipb[PRIO_LEVELS-1-g];
    end

    always_comb begin
        lvl = '0;
        for (int p = PRIO_LEVELS - 1; p >= 0; p--) begin
            if (by_prio[p]) lvl = PRIO_W'(p);
        end
    end

    assign any = |ipb;
endmodule

// File: rtl/tctx_acc_decode.sv
module tctx_acc_decode
    import tctx_pkg::*;
(
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output acc_op_t           op
);
    view_e view;
    logic  priv;

    assign view = view_e'(acc_addr[ADDR_W-1 -: VIEW_W]);
    assign priv = (view != VIEW_USER);

    always_comb begin
        op.off     = acc_addr[OFF_W-1:0];
        op.rd      = acc_valid & ~acc_write;
        op.cppr_wr = acc_valid & acc_write & priv & (op.off == OFF_CPPR);
        op.ack_req = acc_valid & ~acc_write & priv & (op.off == OFF_ACK);
    end
endmodule

// File: rtl/tctx_ctx_regs.sv
module tctx_ctx_regs
    import tctx_pkg::*;
#(
    parameter logic [REG_W-1:0] CPPR_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_op_t           op,
    input  logic [REG_W-1:0]  wdata,
    input  logic              ntf_valid,
    input  logic              ntf_os_path,
    input  logic [PRIO_W-1:0] ntf_prio,
    input  logic [PRIO_W-1:0] cur_lvl,
    input  logic              cur_any,
    output logic [REG_W-1:0]  ipb_q,
    output logic [REG_W-1:0]  cppr_q,
    output logic [REG_W-1:0]  nsr_q,
    output logic              ack_fire
);
    logic              ntf_accept;
    logic [REG_W-1:0]  ipb_d, cppr_d, nsr_d;
    logic [PRIO_W-1:0] nxt_lvl;
    logic              nxt_any;

    assign ack_fire   = op.ack_req & cur_any;
    assign ntf_accept = ntf_valid &
                        ~(ntf_os_path & (ntf_prio == PRIO_W'(PRIO_LEVELS - 1)));

    always_comb begin
        ipb_d = ipb_q;
        if (ack_fire)   ipb_d = ipb_d & ~prio_mask(cur_lvl);
        if (ntf_accept) ipb_d = ipb_d | prio_mask(ntf_prio);
    end

    always_comb begin
        cppr_d = cppr_q;
        if (ack_fire)   cppr_d = REG_W'(cur_lvl);
        if (op.cppr_wr) cppr_d = wdata;
    end

    tctx_prio_enc u_next_enc (
        .ipb (ipb_d),
        .lvl (nxt_lvl),
        .any (nxt_any)
    );

    assign nsr_d = (nxt_any && (REG_W'(nxt_lvl) < cppr_d)) ? NSR_EXC : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ipb_q  <= '0;
            cppr_q <= CPPR_RESET;
            nsr_q  <= '0;
        end else begin
            ipb_q  <= ipb_d;
            cppr_q <= cppr_d;
            nsr_q  <= nsr_d;
        end
    end
endmodule

// File: rtl/tctx_presenter.sv
module tctx_presenter
    import tctx_pkg::*;
#(
    parameter logic [REG_W-1:0] CPPR_RESET = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ntf_valid,
    input  logic               ntf_os_path,
    input  logic [PRIO_W-1:0]  ntf_prio,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [REG_W-1:0]   acc_wdata,
    output logic [RDATA_W-1:0] acc_rdata,
    output logic               irq_out
);
    acc_op_t           op;
    logic [REG_W-1:0]  ipb_q, cppr_q, nsr_q, pipr;
    logic [PRIO_W-1:0] cur_lvl;
    logic              cur_any;
    logic              ack_fire;

    tctx_acc_decode u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .op        (op)
    );

    tctx_prio_enc u_cur_enc (
        .ipb (ipb_q),
        .lvl (cur_lvl),
        .any (cur_any)
    );

    assign pipr = cur_any ? REG_W'(cur_lvl) : PRIO_NONE;

    tctx_ctx_regs #(.CPPR_RESET(CPPR_RESET)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .wdata       (acc_wdata),
        .ntf_valid   (ntf_valid),
        .ntf_os_path (ntf_os_path),
        .ntf_prio    (ntf_prio),
        .cur_lvl     (cur_lvl),
        .cur_any     (cur_any),
        .ipb_q       (ipb_q),
        .cppr_q      (cppr_q),
        .nsr_q       (nsr_q),
        .ack_fire    (ack_fire)
    );

    always_comb begin
        acc_rdata = '0;
        if (op.rd) begin
            case (op.off)
                OFF_NSR:  acc_rdata = RDATA_W'(nsr_q);
                OFF_CPPR: acc_rdata = RDATA_W'(cppr_q);
                OFF_IPB:  acc_rdata = RDATA_W'(ipb_q);
                OFF_PIPR: acc_rdata = RDATA_W'(pipr);
                OFF_ACK:  acc_rdata = {nsr_q, pipr};
                default:  acc_rdata = '0;
            endcase
        end
    end

    assign irq_out = nsr_q[NSR_EXC_BIT];
endmodule

// File: rtl/tctx_presenter_chk.sv
module tctx_presenter_chk
    import tctx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ntf_valid,
    input logic              ntf_os_path,
    input logic [PRIO_W-1:0] ntf_prio,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [REG_W-1:0]  ipb_q,
    input logic [REG_W-1:0]  cppr_q,
    input logic [REG_W-1:0]  pipr,
    input logic              ack_fire,
    input logic              irq_out
);
    logic user_wr;
    assign user_wr = acc_valid & acc_write &
                     (acc_addr[ADDR_W-1 -: VIEW_W] == VIEW_USER);

    // R3
    empty_pipr_chk: assert property (@(posedge clk) disable iff (rst)
        (ipb_q == '0) |-> (pipr == PRIO_NONE));

    // R7
    user_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (user_wr && !ntf_valid) |=> ($stable(cppr_q) && $stable(ipb_q)));

    // R4
    os_prio7_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ntf_valid && ntf_os_path && (ntf_prio == PRIO_W'(PRIO_LEVELS - 1)) && !ack_fire)
        |=> (ipb_q[0] == $past(ipb_q[0])));

    // R8
    ack_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !ntf_valid) |=> !irq_out);

    // R5
    irq_rule_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (pipr < cppr_q));
endmodule

bind tctx_presenter tctx_presenter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ntf_valid   (ntf_valid),
    .ntf_os_path (ntf_os_path),
    .ntf_prio    (ntf_prio),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .ipb_q       (ipb_q),
    .cppr_q      (cppr_q),
    .pipr        (pipr),
    .ack_fire    (ack_fire),
    .irq_out     (irq_out)
);

// File: tb/tb_tctx_presenter.sv
module tb_tctx_presenter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ntf_valid = 1'b0;
    logic        ntf_os_path = 1'b0;
    logic [2:0]  ntf_prio = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_ipb = 0;
    int m_cppr = 0;
    int m_nsr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tctx_presenter dut (
        .clk(clk), .rst(rst),
        .ntf_valid(ntf_valid), .ntf_os_path(ntf_os_path), .ntf_prio(ntf_prio),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_out(irq_out)
    );

    function automatic int pend_prio(input int ipb);
        for (int p = 0; p < 8; p++) if (ipb[7-p]) return p;
        return 255;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one cycle: drive, compare combinational outputs, advance model at the edge
    task automatic step(input bit v, input bit w, input int view, input int off,
                        input int wd, input bit nv, input bit nos, input int np,
                        input string tag);
        int exp_rd, pp, nipb, ncppr;
        bit priv, ack;
        acc_valid = v; acc_write = w; acc_addr = 6'((view << 4) | off);
        acc_wdata = 8'(wd); ntf_valid = nv; ntf_os_path = nos; ntf_prio = 3'(np);
        #1;
        pp = pend_prio(m_ipb);
        exp_rd = 0;
        if (v && !w) begin
            case (off)
                0: exp_rd = m_nsr;
                1: exp_rd = m_cppr;
                2: exp_rd = m_ipb;
                3: exp_rd = pp;
                4: exp_rd = (m_nsr << 8) | pp;
                default: exp_rd = 0;
            endcase
        end
        check({tag, " rdata"}, int'(acc_rdata), exp_rd);
        check({tag, " irq"}, int'(irq_out), (m_nsr >> 7) & 1);
        @(posedge clk);
        priv = (view != 3);
        ack = v && !w && priv && off == 4 && pp != 255;
        nipb = m_ipb; ncppr = m_cppr;
        if (ack) begin nipb = nipb & ~(1 << (7 - pp)); ncppr = pp; end
        if (nv && !(nos && np == 7)) nipb = nipb | (1 << (7 - np));
        if (v && w && priv && off == 1) ncppr = wd;
        m_ipb = nipb; m_cppr = ncppr;
        m_nsr = (pend_prio(m_ipb) < m_cppr) ? 8'h80 : 0;
        @(negedge clk);
    endtask

    task automatic rd(input int view, input int off, input string tag);
        step(1, 0, view, off, 0, 0, 0, 0, tag);
    endtask
    task automatic wr(input int view, input int off, input int wd, input string tag);
        step(1, 1, view, off, wd, 0, 0, 0, tag);
    endtask
    task automatic ntf(input bit os, input int p, input string tag);
        step(0, 0, 0, 0, 0, 1, os, p, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(0, 0, "R1"); rd(0, 1, "R1"); rd(0, 2, "R1"); rd(0, 3, "R1");
        // R2 / R3 notification below mask
        ntf(1, 3, "R2");
        rd(2, 2, "R2"); rd(2, 3, "R3");
        // R6 / R5 open the mask from the OS view
        wr(2, 1, 5, "R6");
        rd(2, 0, "R5"); rd(1, 1, "R6");
        // R7 user write ignored, user read allowed
        wr(3, 1, 0, "R7"); rd(3, 1, "R7"); rd(3, 0, "R7");
        // R3 more favoured pending wins
        ntf(0, 1, "R3"); rd(0, 3, "R3"); rd(0, 2, "R2");
        // R10 user acknowledge has no side effect
        rd(3, 4, "R10"); rd(0, 2, "R10"); rd(0, 1, "R10");
        // R8 acknowledge from OS view
        rd(2, 4, "R8"); rd(2, 1, "R8"); rd(2, 2, "R8"); rd(2, 0, "R8");
        // R4 priority 7 via OS path dropped, via physical path accepted
        wr(1, 1, 8'hFF, "R6");
        ntf(1, 7, "R4"); rd(0, 2, "R4");
        ntf(0, 7, "R4"); rd(0, 2, "R4"); rd(0, 0, "R5");
        // drain, then R9 acknowledge on empty buffer
        rd(0, 4, "R8"); rd(0, 4, "R8"); rd(0, 4, "R9");
        rd(0, 2, "R9"); rd(0, 1, "R9");
        // R11 notification merged with acknowledge
        wr(0, 1, 8'hFF, "R6");
        ntf(0, 2, "R11");
        step(1, 0, 2, 4, 0, 1, 1, 0, "R11");
        rd(0, 2, "R11"); rd(0, 1, "R11"); rd(0, 0, "R11");
        // R12 unknown offsets and non-priority writes
        rd(0, 7, "R12"); rd(1, 15, "R12");
        wr(0, 2, 8'hAA, "R12"); wr(0, 0, 8'h80, "R12"); wr(0, 4, 8'h00, "R12");
        rd(0, 2, "R12"); rd(0, 0, "R12");
        step(0, 1, 0, 2, 8'h55, 0, 0, 0, "R12");
        // mixed random traffic
        for (int i = 0; i < 2000; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            step(sel < 7, sel == 6, int'($urandom_range(0, 3)),
                 (sel == 6) ? ((($urandom_range(0, 3)) == 0) ? 2 : 1) : int'($urandom_range(0, 5)),
                 int'($urandom_range(0, 8)), $urandom_range(0, 2) == 0,
                 $urandom_range(0, 1) == 1, int'($urandom_range(0, 7)), "R5");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule